// File: doc/BRIEF.md
# GPIO pin interrupt controller

This block watches a 12-bit input port and turns activity on its pins into interrupt requests. Each pin has its own setting: it can latch a transition (rising, falling or both) or follow a level (high or low). The block keeps two status vectors. The raw status shows which pins currently meet their interrupt condition. The masked status is that raw status gated by a per-pin enable. The OR of the masked status is the combined request, which reaches the processor's interrupt controller through a two-stage synchronizer.

Software reaches the block through a small word-addressed register bus with an address, a write enable, write data and combinational read data. Latched edges are cleared by writing ones to a write-one-to-clear register. Level-sensitive pins have no latch, so their status drops only when the pin leaves its active level.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0. Raw status, masked status, the per-pin output `mis_o` and `irq_o` are all 0, so every pin is disabled and configured as falling-edge.
- R2: A pin with mode bit 0 (address 0) and polarity bit 1 (address 1) latches its raw status bit (address 4) when the pin goes from 0 to 1 between two clock edges. The bit stays set after the pin returns to 0, and a falling transition does not set it.
- R3: A pin with mode bit 0 and polarity bit 0 latches its raw status on a 1-to-0 transition and ignores a 0-to-1 transition.
- R4: A pin with mode bit 0 and its both-edges bit (address 2) set to 1 latches on either transition, whatever its polarity bit says.
- R5: A pin with mode bit 1 is level-sensitive. Its raw status is 1 exactly while the pin equals its polarity bit, where polarity 1 means active high and polarity 0 means active low, and it returns to 0 as soon as that no longer holds.
- R6: The masked status (read at address 5 and driven on `mis_o`) is the raw status ANDed with the enable register (address 3, where 1 passes the pin).
- R7: Writing the clear register (address 6) clears the edge latch of every pin whose written bit is 1. Bits written as 0 have no effect, and level-sensitive pins are not affected.
- R8: If a pin's edge is detected in the same cycle that its clear bit is written, the latch stays set.
- R9: `irq_o` equals the OR of the masked status delayed by exactly two clocks. After the last enabled latch is cleared, `irq_o` stays high for two more cycles.
- R10: The clear register and unmapped address 7 read 0. Writes to the raw and masked status registers are ignored. Read bits 31:12 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 12 | Port pin levels, already synchronized |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register, combinational |
| mis_o | output | 12 | Per-pin masked interrupt status |
| irq_o | output | 1 | Combined interrupt request after the synchronizer |

## Verification
The bench goes after the clear/edge collision. A design in which the clear wins would drop an interrupt that arrives during the clear write, and the raw status would read 0 instead of 1. It checks that a clear leaves level pins alone and that a zero bit in the clear write has no effect. A design that cleared too widely would zero a level pin's status that should still read 1. It counts the synchronizer's latency on both the rising and the falling side of `irq_o`. A missing or extra stage would move the transition by a cycle and miss the sampled window. It also checks polarity, both-edges and mask behaviour, with pins returning to their idle level. A detector that followed the level instead of latching would report 0 after the pin went back.

// File: rtl/pin_irq_pkg.sv
// Package: shared register addresses for the pin interrupt controller.
// Assumes a word-addressed bus with ADDR_W address bits.
package pin_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,   // 0 = edge, 1 = level
        REG_POL    = 3'd1,   // 1 = rising/high, 0 = falling/low
        REG_BOTH   = 3'd2,   // 1 = either edge (edge pins only)
        REG_ENABLE = 3'd3,   // 1 = pin may drive the combined request
        REG_RAW    = 3'd4,   // read-only raw status
        REG_MASKED = 3'd5,   // read-only masked status
        REG_CLEAR  = 3'd6    // write-one-to-clear of edge latches
    } reg_addr_e;
endpackage

// File: rtl/pin_irq_regs.sv
// Module: configuration registers, clear strobe and read multiplexer.
// Assumes DATA_W > N_PINS; upper read bits are always zero.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int N_PINS = 12,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [N_PINS-1:0]     wdata,
    input  logic [N_PINS-1:0]     raw,
    input  logic [N_PINS-1:0]     mis,
    output logic [N_PINS-1:0]     mode_q,
    output logic [N_PINS-1:0]     pol_q,
    output logic [N_PINS-1:0]     both_q,
    output logic [N_PINS-1:0]     enable_q,
    output logic [N_PINS-1:0]     clr,
    output logic [DATA_W-1:0]     rdata
);
    localparam int PAD_W = DATA_W - N_PINS;

    logic [N_PINS-1:0] sel_val;

    // Update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            pol_q    <= '0;
            both_q   <= '0;
            enable_q <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_MODE:   mode_q   <= wdata;
                REG_POL:    pol_q    <= wdata;
                REG_BOTH:   both_q   <= wdata;
                REG_ENABLE: enable_q <= wdata;
                default:    ;
            endcase
        end
    end

    // Form the one-cycle clear strobe from a write to the clear register.
    always_comb begin
        clr = (wr_en && addr == REG_CLEAR) ? wdata : '0;
    end

    // Select the readable value; the clear and unmapped addresses read zero.
    always_comb begin
        case (addr)
            REG_MODE:   sel_val = mode_q;
            REG_POL:    sel_val = pol_q;
            REG_BOTH:   sel_val = both_q;
            REG_ENABLE: sel_val = enable_q;
            REG_RAW:    sel_val = raw;
            REG_MASKED: sel_val = mis;
            default:    sel_val = '0;
        endcase
        rdata = {{PAD_W{1'b0}}, sel_val};
    end
endmodule

// File: rtl/pin_irq_detect.sv
// Module: per-pin edge latch and level qualifier producing raw status.
// Assumes pins are already synchronous to clk. The previous-value register
// samples even during reset, so a pin held high through reset gives no edge.
module pin_irq_detect #(
    parameter int N_PINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin,
    input  logic [N_PINS-1:0] mode_q,
    input  logic [N_PINS-1:0] pol_q,
    input  logic [N_PINS-1:0] both_q,
    input  logic [N_PINS-1:0] clr,
    output logic [N_PINS-1:0] raw
);
    logic [N_PINS-1:0] prev_q;

    // Keep the pin values of the previous cycle for edge comparison.
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic rise, fall, hit, latch_q;

        // Decode the edge selected by polarity and both-edges settings.
        always_comb begin
            rise = pin[i] & ~prev_q[i];
            fall = ~pin[i] & prev_q[i];
            if (both_q[i]) hit = rise | fall;
            else if (pol_q[i]) hit = rise;
            else hit = fall;
        end

        // Edge latch: a detected edge has priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) latch_q <= 1'b0;
            else if (hit && !mode_q[i]) latch_q <= 1'b1;
            else if (clr[i]) latch_q <= 1'b0;
        end

        // Raw status: level pins follow the pin, edge pins show the latch.
        always_comb begin
            raw[i] = mode_q[i] ? (pin[i] == pol_q[i]) : latch_q;
        end
    end
endmodule

// File: rtl/pin_irq_sync.sv
// Module: reset-clearable shift synchronizer for the combined request.
// Assumes STAGES >= 2.
module pin_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    // Shift the request through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_ctrl.sv
// Module: top of the pin interrupt controller. Connects registers, the
// detector and the output synchronizer; masks raw status with the enables.
// Assumes pin_i is synchronous to clk and DATA_W > N_PINS.
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int N_PINS      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_PINS-1:0] mis_o,
    output logic              irq_o
);
    logic [N_PINS-1:0] mode_q, pol_q, both_q, enable_q, clr, raw_st, mis;
    logic              any_req;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_PINS];

    pin_irq_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i[N_PINS-1:0]), .raw(raw_st), .mis(mis),
        .mode_q(mode_q), .pol_q(pol_q), .both_q(both_q),
        .enable_q(enable_q), .clr(clr), .rdata(rdata_o)
    );

    pin_irq_detect #(.N_PINS(N_PINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .pin(pin_i), .mode_q(mode_q),
        .pol_q(pol_q), .both_q(both_q), .clr(clr), .raw(raw_st)
    );

    // Gate raw status with the enables and merge into one request.
    always_comb begin
        mis     = raw_st & enable_q;
        any_req = |mis;
    end

    assign mis_o = mis;

    pin_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(any_req), .q(irq_o)
    );
endmodule

// File: rtl/pin_irq_chk.sv
// Module: assertion checker bound to pin_irq_ctrl. Watches the ports and
// the raw status and mode vectors that the top connects between submodules.
module pin_irq_chk
    import pin_irq_pkg::*;
#(
    parameter int N_PINS      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [N_PINS-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N_PINS-1:0] raw,
    input logic [N_PINS-1:0] mode_q,
    input logic [N_PINS-1:0] mis,
    input logic              irq
);
    logic [SYNC_STAGES-1:0] hist_q;
    logic [7:0]             since_rst;
    logic                   clr_wr;

    assign clr_wr = wr_en && (addr == REG_CLEAR);

    // Track the combined masked request and the cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q    <= '0;
            since_rst <= '0;
        end else begin
            hist_q <= {hist_q[SYNC_STAGES-2:0], |mis};
            if (since_rst < 8'(SYNC_STAGES)) since_rst <= since_rst + 8'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (mis == '0 && irq == 1'b0));

    for (genvar i = 0; i < N_PINS; i++) begin : g_bit
        a_r2_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_q[i] && raw[i] && !(clr_wr && wdata[i])) |=> (raw[i] || mode_q[i]));
    end

    a_r6_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (mis & ~raw) == '0);

    a_r9_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'(SYNC_STAGES)) |-> (irq == hist_q[SYNC_STAGES-1]));

    a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CLEAR) |-> (rdata == '0));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:N_PINS] == '0);
endmodule

bind pin_irq_ctrl pin_irq_chk #(
    .N_PINS(N_PINS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .wr_en(wr_en_i),
    .wdata(wdata_i[N_PINS-1:0]), .rdata(rdata_o), .raw(raw_st),
    .mode_q(mode_q), .mis(mis_o), .irq(irq_o)
);

// File: tb/tb_pin_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module tb_pin_irq_ctrl;
    import pin_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;
    localparam int DW = 32;
    localparam int K_RD = 0, K_MIS = 1, K_IRQ = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic [2:0]    addr_i = '0;
    logic          wr_en_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic [NP-1:0] mis_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_req[$];

    pin_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .mis_o(mis_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: a quarter period after each falling edge, compare queued items.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        while (q_kind.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string r;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            a = (k == K_RD) ? rdata_o : (k == K_MIS) ? {20'd0, mis_o} : {31'd0, irq_o};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", r, a, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(posedge clk); #1 wr_en_i = 1'b0;
    endtask

    task automatic wr_pin(input logic [2:0] a, input logic [31:0] d, input logic [NP-1:0] p);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1; pin_i = p;
        @(posedge clk); #1 wr_en_i = 1'b0;
    endtask

    task automatic set_pin(input logic [NP-1:0] p);
        @(negedge clk);
        pin_i = p;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        addr_i = a; wr_en_i = 1'b0;
        q_kind.push_back(K_RD); q_exp.push_back(e); q_req.push_back(r);
    endtask

    task automatic exp_sig(input int k, input logic [31:0] e, input string r);
        @(negedge clk);
        q_kind.push_back(k); q_exp.push_back(e); q_req.push_back(r);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        exp_rd(REG_MODE, 0, "R1 mode");
        exp_rd(REG_POL, 0, "R1 polarity");
        exp_rd(REG_ENABLE, 0, "R1 enable");
        exp_rd(REG_RAW, 0, "R1 raw");
        exp_sig(K_MIS, 0, "R1 mis_o");
        exp_sig(K_IRQ, 0, "R1 irq_o");

        // R2: rising edge latch, then R9 latency
        wr(REG_POL, 32'hFFF);
        wr(REG_ENABLE, 32'hFFF);
        set_pin(12'h001);
        exp_rd(REG_RAW, 32'h001, "R2 rising latched");
        exp_sig(K_IRQ, 0, "R9 irq one stage in");
        exp_sig(K_IRQ, 1, "R9 irq after two stages");
        set_pin(12'h000);
        exp_rd(REG_RAW, 32'h001, "R2 held after pin returns");

        // R7: zero bits have no effect; one bit clears; R9 tail
        wr(REG_CLEAR, 32'h000);
        exp_rd(REG_RAW, 32'h001, "R7 zero write no effect");
        wr(REG_CLEAR, 32'h001);
        exp_sig(K_IRQ, 1, "R9 irq held cycle 1");
        exp_sig(K_IRQ, 1, "R9 irq held cycle 2");
        exp_sig(K_IRQ, 0, "R9 irq drops");
        exp_rd(REG_RAW, 32'h000, "R7 edge latch cleared");

        // R3: falling edge on pin 0
        wr(REG_POL, 32'hFFE);
        set_pin(12'h001);
        exp_rd(REG_RAW, 32'h000, "R3 rising ignored");
        set_pin(12'h000);
        exp_rd(REG_RAW, 32'h001, "R3 falling latched");
        wr(REG_CLEAR, 32'h001);
        exp_rd(REG_RAW, 32'h000, "R3 cleared");

        // R4: both edges on pin 1
        wr(REG_BOTH, 32'h002);
        set_pin(12'h002);
        exp_rd(REG_RAW, 32'h002, "R4 rising latched");
        wr(REG_CLEAR, 32'h002);
        set_pin(12'h000);
        exp_rd(REG_RAW, 32'h002, "R4 falling latched");
        wr(REG_CLEAR, 32'h002);
        exp_rd(REG_RAW, 32'h000, "R4 cleared");

        // R6: masking
        wr(REG_ENABLE, 32'h000);
        set_pin(12'h004);
        exp_rd(REG_RAW, 32'h004, "R6 raw set while masked");
        exp_rd(REG_MASKED, 32'h000, "R6 masked read zero");
        exp_sig(K_MIS, 32'h000, "R6 mis_o zero");
        exp_sig(K_IRQ, 0, "R6 irq stays low");
        wr(REG_ENABLE, 32'h004);
        exp_rd(REG_MASKED, 32'h004, "R6 masked after enable");
        set_pin(12'h000);
        wr(REG_CLEAR, 32'h004);
        exp_rd(REG_RAW, 32'h000, "R6 cleanup");

        // R5: level-sensitive pin 3, active high then active low
        wr(REG_ENABLE, 32'hFFF);
        wr(REG_MODE, 32'h008);
        exp_rd(REG_RAW, 32'h000, "R5 high level inactive");
        set_pin(12'h008);
        exp_sig(K_MIS, 32'h008, "R5 level raw follows pin");
        exp_sig(K_IRQ, 1, "R9 level irq after two clocks");
        wr(REG_CLEAR, 32'h008);
        exp_rd(REG_RAW, 32'h008, "R7 clear ignores level pin");
        set_pin(12'h000);
        exp_rd(REG_RAW, 32'h000, "R5 level drops with pin");
        wr(REG_POL, 32'hFF6);
        exp_rd(REG_RAW, 32'h008, "R5 active low level");
        wr(REG_POL, 32'hFFF);
        wr(REG_MODE, 32'h000);
        exp_rd(REG_RAW, 32'h000, "R5 back to edge no latch");

        // R8: set and clear in the same cycle, pin 4
        set_pin(12'h010);
        set_pin(12'h000);
        exp_rd(REG_RAW, 32'h010, "R8 latched before collision");
        wr_pin(REG_CLEAR, 32'h010, 12'h010);
        exp_rd(REG_RAW, 32'h010, "R8 set wins over clear");
        wr(REG_CLEAR, 32'h010);
        exp_rd(REG_RAW, 32'h000, "R8 plain clear afterwards");

        // R10: read-only, write-only and reserved bits
        wr(REG_RAW, 32'hFFF);
        exp_rd(REG_RAW, 32'h000, "R10 raw write ignored");
        wr(REG_MASKED, 32'hFFF);
        exp_rd(REG_MASKED, 32'h000, "R10 masked write ignored");
        exp_rd(REG_CLEAR, 32'h000, "R10 clear reads zero");
        exp_rd(3'd7, 32'h000, "R10 unmapped reads zero");
        wr(REG_ENABLE, 32'hFFFF_FFFF);
        exp_rd(REG_ENABLE, 32'h0000_0FFF, "R10 reserved bits zero");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule